// File: doc/BRIEF.md
# Bitmask Immediate Expander

This block turns a packed 13-bit immediate (a one-bit width selector `n`, a six-bit size-and-length field `s` and a six-bit rotate field `r`) into a 64-bit logical mask. It works in four steps:

- It picks an element width that is a power of two, from 2 to 64 bits.
- It fills the low end of that element with a contiguous run of ones.
- It rotates the element right within its own width.
- It tiles the element across the full 64-bit word.

Encodings that name no legal element width, or that ask for a run filling the whole element, are flagged as reserved.

The decode is purely combinational and is captured by one register stage. A result is loaded on each cycle where `in_valid` is high. `out_valid` reports one clock later that the registered result belongs to that input.

Top module: `bmask_expand`

## Requirements
- R1: The element width `e` is set by the highest set bit of the 7-bit value {n, ~s}:
  - bit 6 (n=1) gives 64;
  - bit 5 (s=0xxxxx) gives 32;
  - bit 4 (s=10xxxx) gives 16;
  - bit 3 (s=110xxx) gives 8;
  - bit 2 (s=1110xx) gives 4;
  - bit 1 (s=11110x) gives 2.
- R2: The run field is s modulo e. Before rotation, the element holds (run field + 1) ones in its least significant bits and zeros above them.
- R3: The element is rotated right, within its own e bits, by r modulo e.
- R4: The rotated element is repeated 64/e times. Element copy k occupies mask bits [k*e + e-1 : k*e].
- R5: n=0 together with s[5:1]=11111 is reserved.
- R6: A run field equal to e-1 (all ones for the selected width) is reserved.
- R7: A reserved encoding gives `out_rsvd`=1 and `out_mask`=0. A legal encoding gives `out_rsvd`=0.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock.
- R9: While `in_valid` is low, `out_mask` and `out_rsvd` keep their last loaded values.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_mask` and `out_rsvd` to zero.
- R11: n=1, s=0x20, r=5 yields 0xF80000000FFFFFFF with `out_rsvd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input fields are valid this cycle |
| in_n | input | 1 | Width selector bit |
| in_s | input | 6 | Size and run-length field |
| in_r | input | 6 | Rotate amount |
| out_valid | output | 1 | Registered result valid |
| out_mask | output | 64 | Expanded mask, zero when reserved |
| out_rsvd | output | 1 | Reserved encoding flag |

## Verification
The bench builds the block with its default parameters: a 64-bit mask and 6-bit fields. With these widths the whole input space is only 8192 codes, so every combination of width selector, size field and rotate field is driven and compared. This includes every reserved code and every rotate value past the element width, each checked against a model that rotates one bit at a time. Directed tasks cover the valid pipeline, holding while idle, and reset in mid-stream.

// File: rtl/bmask_pkg.sv
package bmask_pkg;
  localparam int MASK_W = 64;
  localparam int FLD_W  = 6;
  localparam int LEN_W  = $clog2(FLD_W + 1);

  // index of the highest set bit of v (0 when v is zero)
  function automatic logic [LEN_W-1:0] top_one(input logic [FLD_W:0] v);
    logic [LEN_W-1:0] p;
    p = '0;
    for (int i = 0; i <= FLD_W; i++)
      if (v[i]) p = LEN_W'(i);
    return p;
  endfunction

  // element width minus one for a width exponent
  function automatic logic [FLD_W-1:0] width_mask(input logic [LEN_W-1:0] lg);
    logic [FLD_W:0] one;
    one = 1;
    return FLD_W'((one << lg) - 1'b1);
  endfunction
endpackage

// File: rtl/bmask_size_det.sv
module bmask_size_det
  import bmask_pkg::*;
#(
  parameter int FW = FLD_W
) (
  input  logic             n_i,
  input  logic [FW-1:0]    s_i,
  output logic [LEN_W-1:0] lg_o,
  output logic [FW-1:0]    emask_o,
  output logic             size_ok_o
);
  logic [FW:0] sel_w;

  assign sel_w     = {n_i, ~s_i};
  assign lg_o      = top_one(sel_w);
  assign emask_o   = width_mask(lg_o);
  // no set bit, or only bit 0, names no legal width
  assign size_ok_o = (|sel_w) && (lg_o != '0);
endmodule

// File: rtl/bmask_elem_gen.sv
module bmask_elem_gen
  import bmask_pkg::*;
#(
  parameter int MW = MASK_W,
  parameter int FW = FLD_W
) (
  input  logic [FW-1:0] s_i,
  input  logic [FW-1:0] r_i,
  input  logic [FW-1:0] emask_i,
  output logic [MW-1:0] elem_o,
  output logic [FW-1:0] run_o,
  output logic          run_full_o
);
  logic [FW-1:0] rot_w;

  assign run_o      = s_i & emask_i;
  assign rot_w      = r_i & emask_i;
  assign run_full_o = (run_o == emask_i);

  // right rotation: output bit i takes unrotated bit (i + rot) mod e
  for (genvar i = 0; i < MW; i++) begin : g_bit
    logic [FW-1:0] src;
    assign src       = (FW'(i) + rot_w) & emask_i;
    assign elem_o[i] = (FW'(i) <= emask_i) && (src <= run_o);
  end
endmodule

// File: rtl/bmask_tile.sv
module bmask_tile
  import bmask_pkg::*;
#(
  parameter int MW = MASK_W,
  parameter int FW = FLD_W
) (
  input  logic [MW-1:0] elem_i,
  input  logic [FW-1:0] emask_i,
  output logic [MW-1:0] mask_o
);
  for (genvar i = 0; i < MW; i++) begin : g_rep
    assign mask_o[i] = elem_i[FW'(i) & emask_i];
  end
endmodule

// File: rtl/bmask_expand.sv
module bmask_expand
  import bmask_pkg::*;
#(
  parameter int MW = MASK_W,
  parameter int FW = FLD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_n,
  input  logic [FW-1:0] in_s,
  input  logic [FW-1:0] in_r,
  output logic          out_valid,
  output logic [MW-1:0] out_mask,
  output logic          out_rsvd
);
  logic [LEN_W-1:0] lg_w;
  logic [FW-1:0]    emask_w;
  logic             size_ok_w;
  logic [MW-1:0]    elem_w;
  logic [FW-1:0]    run_w;
  logic             run_full_w;
  logic [MW-1:0]    tiled_w;
  logic             rsvd_w;
  logic [MW-1:0]    mask_w;

  bmask_size_det #(.FW(FW)) u_size (
    .n_i(in_n), .s_i(in_s), .lg_o(lg_w), .emask_o(emask_w), .size_ok_o(size_ok_w)
  );

  bmask_elem_gen #(.MW(MW), .FW(FW)) u_elem (
    .s_i(in_s), .r_i(in_r), .emask_i(emask_w),
    .elem_o(elem_w), .run_o(run_w), .run_full_o(run_full_w)
  );

  bmask_tile #(.MW(MW), .FW(FW)) u_tile (
    .elem_i(elem_w), .emask_i(emask_w), .mask_o(tiled_w)
  );

  assign rsvd_w = !size_ok_w || run_full_w;
  assign mask_w = rsvd_w ? '0 : tiled_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_rsvd  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mask <= mask_w;
        out_rsvd <= rsvd_w;
      end
    end
  end

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_mask) && $stable(out_rsvd)));
  // R7
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_rsvd |-> (out_mask == '0));
  // R1
  wide_legal_chk: assert property (@(posedge clk) disable iff (rst)
    in_n |-> (size_ok_w && emask_w == '1));
  // R2
  run_count_chk: assert property (@(posedge clk) disable iff (rst)
    !rsvd_w |-> ($countones(elem_w) == int'(run_w) + 1));
  // R4
  tile_count_chk: assert property (@(posedge clk) disable iff (rst)
    !rsvd_w |-> ($countones(tiled_w) == ((int'(run_w) + 1) << (FW - int'(lg_w)))));
endmodule

// File: tb/test_bmask_expand.sv
module test_bmask_expand;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_n;
  logic [5:0]  in_s;
  logic [5:0]  in_r;
  logic        out_valid;
  logic [63:0] out_mask;
  logic        out_rsvd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bmask_expand i_bmask_expand (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_n(in_n), .in_s(in_s), .in_r(in_r),
    .out_valid(out_valid), .out_mask(out_mask), .out_rsvd(out_rsvd)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: table of widths, build run, rotate one bit at a time, tile
  task automatic model(input bit n, input logic [5:0] s, input logic [5:0] r,
                       output logic [63:0] m, output bit rs);
    int e, len, rot;
    logic [63:0] el;
    bit lsb;
    casez ({n, s})
      7'b1??????: e = 64;
      7'b00?????: e = 32;
      7'b010????: e = 16;
      7'b0110???: e = 8;
      7'b01110??: e = 4;
      7'b011110?: e = 2;
      default:    e = 0;
    endcase
    m  = '0;
    rs = 1'b0;
    if (e == 0) begin rs = 1'b1; return; end
    len = (int'(s) % e) + 1;
    if (len == e) begin rs = 1'b1; return; end
    rot = int'(r) % e;
    el = '0;
    for (int j = 0; j < len; j++) el[j] = 1'b1;
    for (int k = 0; k < rot; k++) begin
      lsb = el[0];
      el  = el >> 1;
      el[e-1] = lsb;
    end
    for (int b = 0; b < 64; b += e) m = m | (el << b);
  endtask

  task automatic drive(input bit v, input bit n, input logic [5:0] s, input logic [5:0] r);
    @(negedge clk);
    in_valid = v; in_n = n; in_s = s; in_r = r;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b1; in_n = 1'b1; in_s = 6'h05; in_r = 6'h00;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 valid in reset", 64'(out_valid), 64'd0);
    check(out_mask == '0, "R10 mask in reset", out_mask, 64'd0);
    check(out_rsvd == 1'b0, "R10 rsvd in reset", 64'(out_rsvd), 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_example();
    drive(1'b1, 1'b1, 6'h20, 6'd5);
    check(out_mask == 64'hF80000000FFFFFFF, "R11 example mask", out_mask, 64'hF80000000FFFFFFF);
    check(out_rsvd == 1'b0, "R11 example rsvd", 64'(out_rsvd), 64'd0);
    check(out_valid == 1'b1, "R8 valid after load", 64'(out_valid), 64'd1);
  endtask

  task automatic t_hold();
    logic [63:0] m;
    bit rs;
    model(1'b0, 6'b110010, 6'd3, m, rs);
    drive(1'b1, 1'b0, 6'b110010, 6'd3);
    check(out_mask == m, "R4 8-bit tile before hold", out_mask, m);
    drive(1'b0, 1'b1, 6'h3f, 6'd0);
    check(out_mask == m, "R9 mask held", out_mask, m);
    check(out_rsvd == 1'b0, "R9 rsvd held", 64'(out_rsvd), 64'd0);
    check(out_valid == 1'b0, "R8 valid drop", 64'(out_valid), 64'd0);
    drive(1'b1, 1'b0, 6'b111110, 6'd0);
    drive(1'b0, 1'b0, 6'b000000, 6'd0);
    check(out_rsvd == 1'b1, "R9 rsvd held high", 64'(out_rsvd), 64'd1);
    check(out_mask == '0, "R7 reserved mask held zero", out_mask, 64'd0);
  endtask

  task automatic t_exhaustive();
    logic [63:0] m;
    bit rs;
    for (int c = 0; c < 8192; c++) begin
      model(c[12], c[11:6], c[5:0], m, rs);
      drive(1'b1, c[12], c[11:6], c[5:0]);
      if (rs) begin
        check(out_rsvd == 1'b1, "R5/R6 reserved flag", 64'(out_rsvd), 64'd1);
        check(out_mask == '0, "R7 reserved mask", out_mask, 64'd0);
      end else begin
        check(out_rsvd == 1'b0, "R7 legal flag", 64'(out_rsvd), 64'd0);
        check(out_mask == m, "R1/R2/R3/R4 mask", out_mask, m);
      end
    end
  endtask

  task automatic t_mid_reset();
    drive(1'b1, 1'b0, 6'b000000, 6'd1);
    check(out_mask == 64'h8000000080000000, "R3 32-bit rotate by 1", out_mask, 64'h8000000080000000);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_mask == '0, "R10 mid-stream reset", out_mask, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_example();
    t_hold();
    t_exhaustive();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule